// File: doc/BRIEF.md
# Nonvolatile Program Write Guard

This block sits between a CPU register bus and the controller of an on-chip nonvolatile program memory. It stops that memory from being written by accident. Software programs a byte-wide control register and a key port that has no storage. A write or erase only starts when a fixed unlock sequence arrives intact. That sequence is two key bytes followed at once by a control write that sets both the enable and the start bits. Once launched, the block pulses a start strobe to the array and holds the CPU stall line for a timed program window. When the window and the array both finish, it clears the start bit and raises a one-clock completion flag.

The block also keeps the 22-bit program-memory address pointer, which drives the array address. It separates a cold power-up from warm resets. A warm reset caused by the reset pin or the watchdog, arriving while a program operation runs, sets a sticky write-error bit so that software can find and rewrite the damaged location. Reset is synchronous and active-high. The `rst_cause` input tells the kind of reset while `rst` is high.

Top module: `nvm_guard`

## Requirements
- R1: After a power-on reset (`rst_cause` = 0), the control register (address 0) reads 0x00, all three pointer bytes read 0x00, and `cpu_stall`, `arr_start` and `done_irq` are low.
- R2: Control register bits are: 7 memory select, 6 config select, 5 reads 0, 4 erase select (`arr_erase`), 3 write error, 2 write enable, 1 write start, 0 read start. Writing 0x55 and then 0xAA to the key port (address 1), followed at once by a control write with bits 2 and 1 set, raises `cpu_stall` and sets write start. It also pulses `arr_start` for exactly one clock.
- R3: A launch is refused, so that stall stays low and write start reads 0, if any key byte is wrong, out of order or missing, or if any other bus write falls between the key bytes and the start write.
- R4: A start write with bit 2 clear is ignored even directly after a correct key pair.
- R5: With `arr_done` high, `cpu_stall` stays high for exactly PROG_CYCLES clocks (default 16). If `arr_done` is low when that window ends, the stall lasts until `arr_done` returns.
- R6: At the end of an operation, `done_irq` is high for exactly one clock, the clock after the stall falls, and write start then reads 0.
- R7: A read of the key port returns 0x00.
- R8: A reset with cause 1 (reset pin) or 2 (watchdog) during an operation ends the stall and sets the write-error bit. It keeps write start as it was and clears bits 7, 6, 4 and 2. A reset with cause 3 does not set the write-error bit. No completion flag follows an aborted operation.
- R9: A reset with cause other than 0 while idle leaves the write-error bit unchanged. A cause-0 reset clears it.
- R10: Pointer bytes sit at addresses 2 (bits 7:0), 3 (bits 15:8) and 4 (bits 21:16). Address 4 reads its bits 7:6 as 0. `arr_addr` shows the 22-bit pointer.
- R11: Writing 0 to bit 3 or bit 1 of the control register clears that bit. Writing 1 to either one alone never sets it.
- R12: Writing 1 to bit 0 of the control register pulses `arr_read` for one clock. Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cause | input | 2 | Reset kind while rst is high: 0 power, 1 pin, 2 watchdog, 3 other |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 8 | Read data for the address of the previous clock |
| cpu_stall | output | 1 | CPU stall, high while an operation runs |
| arr_start | output | 1 | One-clock start strobe to the array |
| arr_read | output | 1 | One-clock read request to the array |
| arr_erase | output | 1 | Erase select to the array |
| arr_addr | output | 22 | Program-memory address pointer |
| arr_done | input | 1 | Array ready; completion waits for it |
| done_irq | output | 1 | One-clock completion flag |

## Verification
The assertions assume that the CPU issues no bus write while `cpu_stall` is high. A real stalled core cannot, and the block drops such writes in any case. They also assume that `rst_cause` is valid whenever `rst` is high. The bench respects both assumptions. It always waits for the stall to fall before its next write, and it sets the cause in the same clock as the reset. Random trials start with a pointer write, which returns the unlock checker to idle. The expected launch decision therefore depends only on the three writes of the trial. Array back-pressure is applied only by holding `arr_done` low before the timed window ends.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  // register map (key port must be distinct from control; pointer bytes consecutive)
  localparam int A_CTRL = 0;
  localparam int A_KEY  = 1;
  localparam int A_PTR0 = 2;

  // control bit positions
  localparam int B_RDGO  = 0;
  localparam int B_WRGO  = 1;
  localparam int B_WREN  = 2;
  localparam int B_WERR  = 3;
  localparam int B_ERASE = 4;
  localparam int B_CFG   = 6;
  localparam int B_MEM   = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    RC_POWER = 2'd0,
    RC_PIN   = 2'd1,
    RC_WDOG  = 2'd2,
    RC_OTHER = 2'd3
  } rst_cause_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } ul_state_e;
endpackage

// File: rtl/nvg_unlock.sv
module nvg_unlock
  import nvg_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       is_key,
  input  logic [7:0] wdata,
  output logic       armed
);
  ul_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= UL_IDLE;
    end else if (wr_en) begin
      if (is_key) begin
        case (state)
          UL_IDLE: state <= (wdata == KEY_A) ? UL_HALF : UL_IDLE;
          UL_HALF: state <= (wdata == KEY_B) ? UL_ARMED : UL_IDLE;
          default: state <= UL_IDLE;
        endcase
      end else begin
        state <= UL_IDLE;
      end
    end
  end

  assign armed = (state == UL_ARMED);

  // R3
  half_key_chk: assert property (@(posedge clk) disable iff (rst)
    (state == UL_HALF && $past(state) != UL_HALF) |-> $past(wr_en && is_key && wdata == KEY_A));
  // R3
  armed_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(wr_en && is_key && wdata == KEY_B && state == UL_HALF));
endmodule

// File: rtl/nvg_prog_timer.sv
module nvg_prog_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic arr_done,
  output logic busy,
  output logic start_pulse,
  output logic finish
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      start_pulse <= 1'b0;
      finish      <= 1'b0;
    end else begin
      start_pulse <= launch && !busy;
      finish      <= 1'b0;
      if (!busy) begin
        if (launch) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt == LAST && arr_done) begin
        busy   <= 1'b0;
        finish <= 1'b1;
      end else if (cnt != LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> $past(cnt == LAST && arr_done));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !arr_done) |=> busy);
endmodule

// File: rtl/nvg_ptr.sv
module nvg_ptr #(
  parameter int PTR_W = 22,
  localparam int NB = (PTR_W + 7) / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [NB-1:0] sel,
  input  logic [7:0]    wdata,
  output logic [NB*8-1:0] ptr_bytes
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int HI = ((b + 1) * 8 > PTR_W) ? (PTR_W - b * 8) : 8;
    logic [HI-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= '0;
      else if (wr_en && sel[b])
        r <= wdata[HI-1:0];
    end
    assign ptr_bytes[b*8 +: 8] = 8'(r);
  end
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvg_pkg::*;
#(
  parameter int PTR_W       = 22,
  parameter int PROG_CYCLES = 16,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rst_cause,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              cpu_stall,
  output logic              arr_start,
  output logic              arr_read,
  output logic              arr_erase,
  output logic [PTR_W-1:0]  arr_addr,
  input  logic              arr_done,
  output logic              done_irq
);
  localparam int NB = (PTR_W + 7) / 8;

  logic busy, finish, armed, launch;
  logic wr_any, wr_ctrl, wr_key, wr_ptr;
  logic [NB-1:0]   ptr_sel;
  logic [NB*8-1:0] ptr_bytes;
  logic mem_sel, cfg_sel, erase, werr, wren, wrgo, rd_pulse;
  logic [7:0] ctrl_val, rd_next;

  assign wr_any  = bus_we && !busy;
  assign wr_ctrl = wr_any && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_key  = wr_any && (bus_addr == ADDR_W'(A_KEY));
  assign wr_ptr  = wr_any && (ptr_sel != '0);
  assign launch  = wr_ctrl && armed && bus_wdata[B_WRGO] && bus_wdata[B_WREN];

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign ptr_sel[b] = (bus_addr == ADDR_W'(A_PTR0 + b));
  end

  nvg_unlock #(.KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) i_unlock (
    .clk(clk), .rst(rst), .wr_en(wr_any), .is_key(wr_key),
    .wdata(bus_wdata), .armed(armed)
  );

  nvg_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .launch(launch), .arr_done(arr_done),
    .busy(busy), .start_pulse(arr_start), .finish(finish)
  );

  nvg_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_ptr), .sel(ptr_sel),
    .wdata(bus_wdata), .ptr_bytes(ptr_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if (rst_cause == RC_POWER) begin
        werr <= 1'b0;
        wrgo <= 1'b0;
      end else if (busy && (rst_cause == RC_PIN || rst_cause == RC_WDOG)) begin
        werr <= 1'b1;
      end
      mem_sel  <= 1'b0;
      cfg_sel  <= 1'b0;
      erase    <= 1'b0;
      wren     <= 1'b0;
      rd_pulse <= 1'b0;
    end else begin
      rd_pulse <= 1'b0;
      if (finish) wrgo <= 1'b0;
      if (wr_ctrl) begin
        mem_sel  <= bus_wdata[B_MEM];
        cfg_sel  <= bus_wdata[B_CFG];
        erase    <= bus_wdata[B_ERASE];
        wren     <= bus_wdata[B_WREN];
        rd_pulse <= bus_wdata[B_RDGO];
        if (!bus_wdata[B_WERR]) werr <= 1'b0;
        if (!bus_wdata[B_WRGO]) wrgo <= 1'b0;
        else if (launch)        wrgo <= 1'b1;
      end
    end
  end

  assign ctrl_val = {mem_sel, cfg_sel, 1'b0, erase, werr, wren, wrgo, 1'b0};

  always_comb begin
    rd_next = 8'h00;
    if (bus_addr == ADDR_W'(A_CTRL)) rd_next = ctrl_val;
    for (int b = 0; b < NB; b++)
      if (ptr_sel[b]) rd_next = ptr_bytes[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_next;
  end

  assign cpu_stall = busy;
  assign done_irq  = finish;
  assign arr_read  = rd_pulse;
  assign arr_erase = erase;
  assign arr_addr  = ptr_bytes[PTR_W-1:0];

  // R2
  start_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> cpu_stall);
  // R2
  launch_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |-> $past(armed && bus_we && bus_wdata[B_WREN]));
  // R6
  irq_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(cpu_stall) && !cpu_stall));
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  // R12
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    arr_read |-> $past(bus_we && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[B_RDGO]));
endmodule

// File: tb/test_nvm_guard.sv
module test_nvm_guard;
  import nvg_pkg::*;
  localparam int P  = 16;
  localparam int PW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rst_cause = 2'd0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic cpu_stall, arr_start, arr_read, arr_erase, done_irq;
  logic [PW-1:0] arr_addr;
  logic arr_done = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  nvm_guard #(.PTR_W(PW), .PROG_CYCLES(P), .ADDR_W(3)) i_nvm_guard (
    .clk(clk), .rst(rst), .rst_cause(rst_cause), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .cpu_stall(cpu_stall), .arr_start(arr_start), .arr_read(arr_read),
    .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_done(arr_done),
    .done_irq(done_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset(input logic [1:0] cause);
    @(negedge clk);
    rst = 1'b1; rst_cause = cause;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic unlock_start(input logic [7:0] cbits);
    wr(3'(A_KEY), KEY_FIRST);
    wr(3'(A_KEY), KEY_SECOND);
    wr(3'(A_CTRL), cbits);
  endtask

  // called right after the launching write; measures the stall
  task automatic wait_done(input int extra, output int len, output logic st0,
                           output logic st1, output logic irq);
    len = 0; st0 = arr_start; st1 = 1'b0;
    if (extra > 0) arr_done = 1'b0;
    while (cpu_stall && len < 1000) begin
      len++;
      if (len == P + extra) arr_done = 1'b1;
      @(negedge clk);
      if (len == 1) st1 = arr_start;
    end
    arr_done = 1'b1;
    irq = done_irq;
  endtask

  function automatic bit pred_launch(input logic [2:0] a0, input logic [7:0] d0,
                                     input logic [2:0] a1, input logic [7:0] d1,
                                     input logic [2:0] a2, input logic [7:0] d2);
    return a0 == 3'(A_KEY) && d0 == 8'h55 && a1 == 3'(A_KEY) && d1 == 8'hAA &&
           a2 == 3'(A_CTRL) && d2[1] && d2[2];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int len;
    logic s0, s1, irq;
    void'($urandom(32'd2024));
    rst = 1'b1; rst_cause = RC_POWER;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 stall", 32'(cpu_stall), 0);
    chk("R1 start", 32'(arr_start), 0);
    chk("R1 irq", 32'(done_irq), 0);
    rd(3'(A_CTRL), r); chk("R1 ctrl", 32'(r), 0);
    for (int b = 0; b < 3; b++) begin
      rd(3'(A_PTR0 + b), r); chk("R1 ptr", 32'(r), 0);
    end

    // R10 pointer bytes
    wr(3'(A_PTR0 + 2), 8'hFF);
    wr(3'(A_PTR0 + 1), 8'hA5);
    wr(3'(A_PTR0), 8'h3C);
    rd(3'(A_PTR0 + 2), r); chk("R10 upper byte", 32'(r), 32'h3F);
    rd(3'(A_PTR0 + 1), r); chk("R10 mid byte", 32'(r), 32'hA5);
    chk("R10 arr_addr", 32'(arr_addr), 32'h3FA53C);

    // R2 / R5 / R6 directed launch with erase and memory select
    unlock_start(8'h96);
    chk("R2 stall rises", 32'(cpu_stall), 1);
    chk("R2 erase out", 32'(arr_erase), 1);
    wait_done(0, len, s0, s1, irq);
    chk("R2 start pulse", 32'(s0), 1);
    chk("R2 start one clock", 32'(s1), 0);
    chk("R5 stall length", 32'(len), 32'(P));
    chk("R6 irq", 32'(irq), 1);
    @(negedge clk);
    chk("R6 irq one clock", 32'(done_irq), 0);
    rd(3'(A_CTRL), r); chk("R6 start cleared", 32'(r), 32'h94);

    // R5 array back-pressure
    unlock_start(8'h06);
    wait_done(3, len, s0, s1, irq);
    chk("R5 stretched stall", 32'(len), 32'(P + 3));
    chk("R6 irq after stretch", 32'(irq), 1);

    // R7 key port reads zero
    wr(3'(A_KEY), 8'h55);
    rd(3'(A_KEY), r); chk("R7 key read", 32'(r), 0);

    // R3 directed broken sequences
    wr(3'(A_KEY), 8'h55); wr(3'(A_PTR0), 8'h11); wr(3'(A_KEY), 8'hAA); wr(3'(A_CTRL), 8'h06);
    chk("R3 interleaved write", 32'(cpu_stall), 0);
    wr(3'(A_KEY), 8'h55); wr(3'(A_KEY), 8'h55); wr(3'(A_KEY), 8'hAA); wr(3'(A_CTRL), 8'h06);
    chk("R3 repeated first key", 32'(cpu_stall), 0);
    wr(3'(A_KEY), 8'hAA); wr(3'(A_KEY), 8'h55); wr(3'(A_CTRL), 8'h06);
    chk("R3 swapped keys", 32'(cpu_stall), 0);
    rd(3'(A_CTRL), r); chk("R3 start reads 0", 32'(r), 32'h04);

    // R4 enable clear
    wr(3'(A_PTR0), 8'h00);
    unlock_start(8'h02);
    chk("R4 no stall", 32'(cpu_stall), 0);
    rd(3'(A_CTRL), r); chk("R4 start ignored", 32'(r), 0);

    // R12 read request
    wr(3'(A_CTRL), 8'h01);
    chk("R12 read pulse", 32'(arr_read), 1);
    @(negedge clk);
    chk("R12 read one clock", 32'(arr_read), 0);
    rd(3'(A_CTRL), r); chk("R12 bit0 reads 0", 32'(r), 0);

    // R8 pin reset mid-operation
    unlock_start(8'hD6);
    repeat (5) @(negedge clk);
    do_reset(RC_PIN);
    chk("R8 stall dropped", 32'(cpu_stall), 0);
    repeat (P + 2) begin
      @(negedge clk);
      chk("R8 no irq after abort", 32'(done_irq), 0);
    end
    rd(3'(A_CTRL), r); chk("R8 pin abort", 32'(r), 32'h0A);

    // R11 write-one no effect, write-zero clears
    wr(3'(A_CTRL), 8'h08);
    rd(3'(A_CTRL), r); chk("R11 werr kept, start cleared", 32'(r), 32'h08);
    wr(3'(A_CTRL), 8'h20);
    rd(3'(A_CTRL), r); chk("R11 werr cleared, bit5 zero", 32'(r), 0);

    // R8 other-cause reset keeps werr clear
    unlock_start(8'h06);
    repeat (3) @(negedge clk);
    do_reset(RC_OTHER);
    rd(3'(A_CTRL), r); chk("R8 other cause", 32'(r), 32'h02);
    wr(3'(A_CTRL), 8'h00);

    // R8 watchdog abort, then R9 idle warm and cold resets
    unlock_start(8'h06);
    repeat (2) @(negedge clk);
    do_reset(RC_WDOG);
    rd(3'(A_CTRL), r); chk("R8 watchdog abort", 32'(r), 32'h0A);
    wr(3'(A_CTRL), 8'h08);
    do_reset(RC_PIN);
    rd(3'(A_CTRL), r); chk("R9 idle warm reset keeps werr", 32'(r), 32'h08);
    do_reset(RC_POWER);
    rd(3'(A_CTRL), r); chk("R9 power reset clears", 32'(r), 0);
    chk("R1 pointer after power", 32'(arr_addr), 0);

    // random trials: R2 R3 R4 R5 R6 R10
    for (int t = 0; t < 60; t++) begin
      logic [2:0] a [3];
      logic [7:0] d [3];
      logic [7:0] p0;
      int extra;
      p0 = 8'($urandom);
      wr(3'(A_PTR0), p0);
      chk("R10 random low byte", 32'(arr_addr[7:0]), 32'(p0));
      for (int i = 0; i < 3; i++) begin
        if ($urandom % 4 != 0) begin
          a[i] = (i == 2) ? 3'(A_CTRL) : 3'(A_KEY);
          d[i] = (i == 0) ? 8'h55 : (i == 1) ? 8'hAA : ((8'($urandom) & 8'hF6) | 8'h06);
        end else begin
          a[i] = 3'($urandom % 5);
          d[i] = 8'($urandom) & 8'hF7;
        end
        wr(a[i], d[i]);
      end
      if (pred_launch(a[0], d[0], a[1], d[1], a[2], d[2])) begin
        chk("R2 random launch", 32'(cpu_stall), 1);
        extra = int'($urandom % 3);
        wait_done(extra, len, s0, s1, irq);
        chk("R5 random length", 32'(len), 32'(P + extra));
        chk("R6 random irq", 32'(irq), 1);
      end else begin
        chk("R3 random refuse", 32'(cpu_stall), 0);
      end
      rd(3'(A_CTRL), r);
      chk("R6 random start bit", 32'(r[1]), 0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule